// File: doc/BRIEF.md
# Prescaled Event Timer with Wrap Flag

This block is an eight-bit up-counter that advances on one of two event sources. The first source is an internal tick that divides the system clock by two or by four. The second source is an external pin, which a two-stage synchronizer brings into the clock domain. An edge selector then chooses whether rising or falling transitions of that pin count. The chosen events pass through a prescaler. When the prescaler is assigned to this timer, it forwards one event in every 2^(n+1), where n is a three-bit select. When the prescaler is assigned elsewhere, every event passes straight through.

Software can load the count from the data bus at any time and read it back on the count port. A load also clears the prescaler. A small controller then drops the next two increment opportunities, so a freshly written value stays visible for a while. When the counter wraps from all ones to zero, it raises a sticky wrap flag. That flag stays high until a clear strobe arrives.

The controller has three states. `ST_RUN` is the normal counting state. `ST_SKIP1` and `ST_SKIP2` hold the count after a load. Its transitions are:
- load: any state goes to `ST_SKIP1` on a write.
- skip_advance: `ST_SKIP1` goes to `ST_SKIP2` on an increment opportunity.
- skip_done: `ST_SKIP2` goes to `ST_RUN` on an increment opportunity.
- count: `ST_RUN` stays in `ST_RUN` and increments.

Top module: `tmr8_timer`

## Requirements
- R1: While reset is low, and at the first sample after it is released, count is 0x00 and ovf_flag is 0.
- R2: With the internal source (src_ext=0) and the prescaler not assigned (ps_to_tmr=0), the count advances by one every 2 clocks when div_long=0 and every 4 clocks when div_long=1. The first increment after reset lands on the 2nd (or 4th) rising clock edge.
- R3: With src_ext=1 and edge_fall=0, the count advances once for each rising transition of ext_pin. A level first sampled high at clock edge k changes the count at edge k+2. Internal ticks are ignored while the pin source is selected.
- R4: With src_ext=1 and edge_fall=1, only falling transitions of ext_pin count, with the same two-edge latency.
- R5: With ps_to_tmr=1 and ps_sel=n, the count advances once per 2^(n+1) source events, from 2 at n=0 to 256 at n=7. With ps_to_tmr=0, every source event advances it.
- R6: A cycle with wr_en=1 loads wr_data into count at that clock edge and clears the prescaler. The load overrides any increment in the same cycle.
- R7: After a load, the first two increment opportunities leave the count unchanged (states ST_SKIP1 and ST_SKIP2). The third one increments it (state ST_RUN).
- R8: An increment from 0xFF to 0x00 sets ovf_flag at the same edge. The flag then stays 1 until it is cleared.
- R9: ovf_clr=1 clears ovf_flag at the next edge. If a wrap happens in the same cycle as the clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| div_long | input | 1 | Internal tick rate: 0 = clock/2, 1 = clock/4 |
| src_ext | input | 1 | Event source: 0 = internal tick, 1 = external pin |
| ext_pin | input | 1 | External event pin, asynchronous |
| edge_fall | input | 1 | Counted pin edge: 0 = rising, 1 = falling |
| ps_sel | input | 3 | Prescale select n, ratio 2^(n+1) |
| ps_to_tmr | input | 1 | 1 = prescaler assigned to this timer |
| wr_en | input | 1 | Count register write strobe |
| wr_data | input | 8 | Count register write data |
| ovf_clr | input | 1 | Wrap flag clear strobe |
| count | output | 8 | Current count value |
| ovf_flag | output | 1 | Sticky wrap flag |

## Verification
The properties assume that wr_en and ovf_clr are single-cycle strobes that are sampled synchronously. They also assume that the configuration inputs can change at any clock edge without breaking the one-step-at-a-time count rule. The stimulus keeps to these assumptions by driving every input away from the active edge. ext_pin is held for at least one full clock in most phases, so that each transition is seen by the synchronizer. Writes and clears are kept sparse enough that wraps and load holds are actually reached.

// File: rtl/tmr8_pkg.sv
package tmr8_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_SKIP1 = 2'd1,
        ST_SKIP2 = 2'd2
    } tmr_state_t;
endpackage

// File: rtl/tmr8_tick_gen.sv
module tmr8_tick_gen #(
    parameter int DIV_W = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic div_long,
    output logic tick
);
    logic [DIV_W-1:0] dcnt;
    logic [DIV_W-1:0] last;

    always_comb begin
        last = div_long ? {DIV_W{1'b1}} : DIV_W'(1);
        tick = (dcnt == last);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dcnt <= '0;
        end else if (dcnt >= last) begin
            dcnt <= '0;
        end else begin
            dcnt <= dcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr8_pin_sync.sv
module tmr8_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    input  logic edge_fall,
    output logic edge_pulse
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh[0] <= 1'b0;
        end else begin
            sh[0] <= pin;
        end
    end

    for (genvar g = 1; g <= STAGES; g++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sh[g] <= 1'b0;
            end else begin
                sh[g] <= sh[g-1];
            end
        end
    end

    always_comb begin
        if (edge_fall) begin
            edge_pulse = !sh[STAGES-1] && sh[STAGES];
        end else begin
            edge_pulse = sh[STAGES-1] && !sh[STAGES];
        end
    end
endmodule

// File: rtl/tmr8_prescaler.sv
module tmr8_prescaler #(
    parameter int SEL_W = 3,
    localparam int PS_W = 2 ** SEL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             ev_in,
    input  logic             assigned,
    input  logic [SEL_W-1:0] sel,
    output logic             ev_out
);
    logic [PS_W-1:0] pcnt;
    logic [PS_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PS_W; i++) begin
            mask[i] = (i <= int'(sel));
        end
        if (assigned) begin
            ev_out = ev_in && ((pcnt & mask) == mask);
        end else begin
            ev_out = ev_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt <= '0;
        end else if (clr) begin
            pcnt <= '0;
        end else if (ev_in) begin
            pcnt <= pcnt + 1'b1;
        end
    end
endmodule

// File: rtl/tmr8_timer.sv
module tmr8_timer
    import tmr8_pkg::*;
#(
    parameter int CNT_W       = 8,
    parameter int SEL_W       = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             div_long,
    input  logic             src_ext,
    input  logic             ext_pin,
    input  logic             edge_fall,
    input  logic [SEL_W-1:0] ps_sel,
    input  logic             ps_to_tmr,
    input  logic             wr_en,
    input  logic [CNT_W-1:0] wr_data,
    input  logic             ovf_clr,
    output logic [CNT_W-1:0] count,
    output logic             ovf_flag
);
    tmr_state_t     state, state_nx;
    logic           int_tick;
    logic           pin_ev;
    logic           src_ev;
    logic           inc;
    logic           do_step;
    logic [CNT_W:0] sum;

    tmr8_tick_gen #(.DIV_W(2)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .div_long (div_long),
        .tick     (int_tick)
    );

    tmr8_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin        (ext_pin),
        .edge_fall  (edge_fall),
        .edge_pulse (pin_ev)
    );

    assign src_ev = src_ext ? pin_ev : int_tick;

    tmr8_prescaler #(.SEL_W(SEL_W)) u_ps (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (wr_en),
        .ev_in    (src_ev),
        .assigned (ps_to_tmr),
        .sel      (ps_sel),
        .ev_out   (inc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:   state_nx = ST_RUN;
            ST_SKIP1: if (inc) state_nx = ST_SKIP2;
            ST_SKIP2: if (inc) state_nx = ST_RUN;
            default:  state_nx = ST_RUN;
        endcase
        if (wr_en) begin
            state_nx = ST_SKIP1;
        end
    end

    always_comb begin
        do_step = inc && (state == ST_RUN) && !wr_en;
        sum     = {1'b0, count} + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '0;
            ovf_flag <= 1'b0;
        end else begin
            if (wr_en) begin
                count <= wr_data;
            end else if (do_step) begin
                count <= sum[CNT_W-1:0];
            end
            if (do_step && sum[CNT_W]) begin
                ovf_flag <= 1'b1;
            end else if (ovf_clr) begin
                ovf_flag <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/tmr8_timer_chk.sv
module tmr8_timer_chk #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [CNT_W-1:0] wr_data,
    input logic             ovf_clr,
    input logic [CNT_W-1:0] count,
    input logic             ovf_flag
);
    // R6: a write shows up in the count at the next sample
    p_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (count == $past(wr_data)));

    // R7: the first opportunity after a load cannot move the count
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en ##1 !wr_en |=> $stable(count));

    // R2: without a write the count moves by at most one step
    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)));

    // R8: a wrap from all ones sets the flag
    p_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && count == '1) |=> (count != '0 || ovf_flag));

    // R8: the flag rises only on a wrap
    p_rise_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ovf_flag) |-> (count == '0 && $past(count) == '1 && !$past(wr_en)));

    // R9: the flag stays set without a clear
    p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);
endmodule

bind tmr8_timer tmr8_timer_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .ovf_clr  (ovf_clr),
    .count    (count),
    .ovf_flag (ovf_flag)
);

// File: tb/tmr8_timer_bench.sv
`timescale 1ns/1ps
module tmr8_timer_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       div_long = 1'b0;
    logic       src_ext = 1'b0;
    logic       ext_pin = 1'b0;
    logic       edge_fall = 1'b0;
    logic [2:0] ps_sel = 3'd7;
    logic       ps_to_tmr = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       ovf_clr = 1'b0;
    logic [7:0] count;
    logic       ovf_flag;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tmr8_timer u_tmr8_timer (
        .clk(clk), .rst_n(rst_n), .div_long(div_long), .src_ext(src_ext),
        .ext_pin(ext_pin), .edge_fall(edge_fall), .ps_sel(ps_sel),
        .ps_to_tmr(ps_to_tmr), .wr_en(wr_en), .wr_data(wr_data),
        .ovf_clr(ovf_clr), .count(count), .ovf_flag(ovf_flag)
    );

    // behavioural expectation derived from the requirements
    int   m_d, m_p, m_skip;
    bit   m_s1, m_s2, m_s3, m_flag;
    logic [7:0] m_cnt;

    function automatic bit ps_pass(input int p, input int sel, input bit asg);
        int mask;
        mask = (1 << (sel + 1)) - 1;
        return !asg || ((p & mask) == mask);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_d = 0; m_p = 0; m_skip = 0;
            m_s1 = 0; m_s2 = 0; m_s3 = 0; m_flag = 0; m_cnt = 8'h00;
        end else begin
            int  last;
            bit  itick, ev, inc, wrap;
            last  = div_long ? 3 : 1;
            itick = (m_d == last);
            m_d   = (m_d >= last) ? 0 : m_d + 1;
            ev    = src_ext ? (edge_fall ? (!m_s2 && m_s3) : (m_s2 && !m_s3)) : itick;
            m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_pin;
            inc  = ev && ps_pass(m_p, int'(ps_sel), ps_to_tmr);
            wrap = 0;
            if (wr_en) begin
                m_cnt = wr_data; m_skip = 2; m_p = 0;
            end else begin
                if (ev) m_p = (m_p + 1) & 255;
                if (inc) begin
                    if (m_skip > 0) m_skip--;
                    else begin
                        wrap  = (m_cnt == 8'hFF);
                        m_cnt = m_cnt + 8'h01;
                    end
                end
            end
            if (wrap) m_flag = 1;
            else if (ovf_clr) m_flag = 0;
        end
    end

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic cyc(input string tag);
        @(posedge clk);
        @(negedge clk);
        check(tag, count, m_cnt);
        check("R8 flag", {7'd0, ovf_flag}, {7'd0, m_flag});
    endtask

    task automatic run(input string tag, input int n);
        for (int i = 0; i < n; i++) cyc(tag);
    endtask

    task automatic write(input logic [7:0] v, input string tag);
        wr_en = 1'b1; wr_data = v;
        cyc(tag);
        wr_en = 1'b0;
    endtask

    task automatic pin_pulses(input string tag, input int n);
        for (int i = 0; i < n; i++) begin
            ext_pin = ~ext_pin;
            run(tag, 1 + ($urandom % 3));
        end
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        check("R1 reset count", count, 8'h00);
        check("R1 reset flag", {7'd0, ovf_flag}, 8'h00);
        rst_n = 1'b1;
        cyc("R1");

        // internal source, ratio 1:1
        ps_to_tmr = 1'b0;
        div_long = 1'b0; run("R2", 40);
        check("R2 div2 progress", (count != 8'h00) ? 8'h01 : 8'h00, 8'h01);
        div_long = 1'b1; run("R2", 60);

        // prescaler ratios
        ps_to_tmr = 1'b1;
        div_long = 1'b0;
        for (int s = 0; s < 8; s++) begin
            ps_sel = 3'(s);
            write(8'h00, "R6");
            run("R5", (s < 5) ? 200 : 1100);
        end
        ps_to_tmr = 1'b0;

        // external pin, rising and falling
        src_ext = 1'b1;
        edge_fall = 1'b0; run("R3", 4);
        pin_pulses("R3", 30);
        run("R3", 20);
        edge_fall = 1'b1; run("R4", 4);
        pin_pulses("R4", 30);
        run("R4", 6);
        src_ext = 1'b0;

        // load hold and wrap
        write(8'hFC, "R6");
        check("R6 loaded", count, 8'hFC);
        run("R7", 3);
        check("R7 held", count, 8'hFC);
        run("R8", 20);
        check("R8 wrapped flag", {7'd0, ovf_flag}, 8'h01);
        ovf_clr = 1'b1; cyc("R9"); ovf_clr = 1'b0;
        check("R9 cleared", {7'd0, ovf_flag}, 8'h00);

        // clear coinciding with wrap: find the wrap cycle from the model
        write(8'hFF, "R6");
        while (!(m_skip == 0 && m_d == 1 && m_cnt == 8'hFF)) cyc("R9");
        ovf_clr = 1'b1; cyc("R9"); ovf_clr = 1'b0;
        check("R9 set wins", {7'd0, ovf_flag}, 8'h01);

        // constrained random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 3 == 0) ext_pin = ~ext_pin;
            wr_en   = ($urandom % 40 == 0);
            wr_data = 8'($urandom);
            ovf_clr = ($urandom % 25 == 0);
            if ($urandom % 150 == 0) begin
                src_ext   = 1'($urandom);
                edge_fall = 1'($urandom);
                div_long  = 1'($urandom);
                ps_to_tmr = 1'($urandom);
                ps_sel    = 3'($urandom % 3);
            end
            cyc("R6 mix");
        end
        wr_en = 1'b0; ovf_clr = 1'b0;
        run("R2", 4);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule